// File: doc/BRIEF.md
# Rotate, Shift and Bit-Test Unit

This block is a purely combinational 8-bit datapath slice that sits beside an accumulator-style ALU. Given an operand byte, the present flag byte and an operation code, it produces the rotated or shifted byte together with a freshly computed flag byte in the same cycle. It also performs single-bit tests, where the operand passes through unchanged and only the flags are updated.

The caller supplies a 3-bit index for bit tests. For the indexed form of the bit test, the caller also supplies the upper byte of the effective address. Sequencing of memory read-modify-write cycles belongs to the surrounding controller.

The block holds no state, so it has no state register and no transitions. The operation code is the only selector.

Top module: `rsb_unit`

## Requirements
- R1: Code 0 (rotate left circular): the result is the operand rotated left by one. Old bit 7 lands in both result bit 0 and the carry flag.
- R2: Code 1 (rotate right circular): the result is the operand rotated right by one. Old bit 0 lands in both result bit 7 and the carry flag.
- R3: Code 2 (rotate left via carry) and code 3 (rotate right via carry) move the incoming carry flag into the vacated end bit. The bit pushed out at the other end becomes the new carry.
- R4: Code 4 (arithmetic left shift) fills bit 0 with 0. Code 6 (left shift filling one) fills bit 0 with 1. In both, old bit 7 becomes the carry.
- R5: Code 5 (arithmetic right shift) keeps bit 7 as it was. Code 7 (logical right shift) fills bit 7 with 0. In both, old bit 0 becomes the carry.
- R6: The flag byte layout is: bit 0 carry, bit 1 subtract, bit 2 parity/overflow, bit 3 copy X, bit 4 half carry, bit 5 copy Y, bit 6 zero, bit 7 sign. For codes 0 to 7, the subtract and half-carry flags are 0. Sign, zero, X (result bit 3) and Y (result bit 5) follow the result. Parity/overflow is 1 when the result holds an even number of ones.
- R7: For codes 8 (bit test) and 9 (indexed bit test), the result equals the operand and the carry flag keeps its input value. Half carry is set and subtract is cleared. Zero and parity/overflow are both 1 exactly when the operand bit chosen by the index is 0.
- R8: For the bit tests, sign is 1 only when the index is 7 and operand bit 7 is 1.
- R9: For code 8, the X and Y flags copy operand bits 3 and 5.
- R10: For code 9, the X and Y flags copy bits 3 and 5 of the address upper byte rather than the operand.
- R11: Codes 10 to 15 return the operand and the input flag byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (0..9 defined) |
| val_in | input | 8 | Operand byte |
| flags_in | input | 8 | Present flag byte |
| bit_idx | input | 3 | Bit index for bit tests |
| addr_hi | input | 8 | Upper byte of effective address for indexed bit test |
| val_out | output | 8 | Result byte |
| flags_out | output | 8 | New flag byte |

## Verification
The bench sweeps every operand value under every rotate and shift code with both carry inputs. A swapped fill bit, a dropped carry or an inverted parity sense therefore shows up on the first affected operand.

Bit tests are run across all eight indices on operands that have only that bit set or only that bit clear. This exposes a design that tests the wrong bit, or that raises sign for indices below 7.

The indexed bit test is given an address byte whose bits 3 and 5 differ from the operand's. A design that copies X and Y from the operand would show the operand's bits there.

Undefined codes are driven with a carry-set flag byte, which catches any design that recomputes flags for them.

// File: rtl/rsb_pkg.sv
`timescale 1ns/1ps
package rsb_pkg;
    localparam int DATA_W = 8;
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int OP_W   = 4;

    // Flag byte positions; the surrounding core decodes these
    localparam int FL_C  = 0;
    localparam int FL_N  = 1;
    localparam int FL_PV = 2;
    localparam int FL_X  = 3;
    localparam int FL_H  = 4;
    localparam int FL_Y  = 5;
    localparam int FL_Z  = 6;
    localparam int FL_S  = 7;

    localparam logic [DATA_W-1:0] XY_MASK = DATA_W'((1 << FL_X) | (1 << FL_Y));

    typedef enum logic [OP_W-1:0] {
        OP_RLC  = 4'd0,
        OP_RRC  = 4'd1,
        OP_RL   = 4'd2,
        OP_RR   = 4'd3,
        OP_SLA  = 4'd4,
        OP_SRA  = 4'd5,
        OP_SLL  = 4'd6,
        OP_SRL  = 4'd7,
        OP_BIT  = 4'd8,
        OP_BITX = 4'd9
    } rsb_op_e;
endpackage

// File: rtl/rsb_shift_core.sv
`timescale 1ns/1ps
module rsb_shift_core
    import rsb_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  rsb_op_e        op,
    input  logic [W-1:0]   val,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           cout
);
    localparam int MSB = W - 1;

    always_comb begin
        res  = val;
        cout = cin;
        unique case (op)
            OP_RLC: begin res = {val[MSB-1:0], val[MSB]}; cout = val[MSB]; end
            OP_RRC: begin res = {val[0], val[MSB:1]};     cout = val[0];   end
            OP_RL:  begin res = {val[MSB-1:0], cin};      cout = val[MSB]; end
            OP_RR:  begin res = {cin, val[MSB:1]};        cout = val[0];   end
            OP_SLA: begin res = {val[MSB-1:0], 1'b0};     cout = val[MSB]; end
            OP_SLL: begin res = {val[MSB-1:0], 1'b1};     cout = val[MSB]; end
            OP_SRA: begin res = {val[MSB], val[MSB:1]};   cout = val[0];   end
            OP_SRL: begin res = {1'b0, val[MSB:1]};       cout = val[0];   end
            default: begin res = val; cout = cin; end
        endcase
    end
endmodule

// File: rtl/rsb_sz_flags.sv
`timescale 1ns/1ps
module rsb_sz_flags
    import rsb_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] res,
    output logic         sign,
    output logic         zero,
    output logic         par_even
);
    logic [W:0] chain;
    assign chain[0] = 1'b1;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_par
            assign chain[gi+1] = chain[gi] ^ res[gi];
        end
    endgenerate

    assign par_even = chain[W];
    assign sign     = res[W-1];
    assign zero     = (res == '0);
endmodule

// File: rtl/rsb_bit_test.sv
`timescale 1ns/1ps
module rsb_bit_test
    import rsb_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int IW = IDX_W
) (
    input  logic [W-1:0]  val,
    input  logic [IW-1:0] idx,
    input  logic [W-1:0]  xy_src,
    input  logic          cin,
    output logic [W-1:0]  flags
);
    localparam logic [IW-1:0] TOP_IDX = IW'(W - 1);

    logic bit_clear;
    assign bit_clear = ~val[idx];

    always_comb begin
        flags        = xy_src & XY_MASK;
        flags[FL_C]  = cin;
        flags[FL_N]  = 1'b0;
        flags[FL_H]  = 1'b1;
        flags[FL_Z]  = bit_clear;
        flags[FL_PV] = bit_clear;
        flags[FL_S]  = (idx == TOP_IDX) && val[W-1];
    end
endmodule

// File: rtl/rsb_unit.sv
`timescale 1ns/1ps
module rsb_unit
    import rsb_pkg::*;
(
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DATA_W-1:0] val_in,
    input  logic [DATA_W-1:0] flags_in,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic [DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0] val_out,
    output logic [DATA_W-1:0] flags_out
);
    rsb_op_e op;
    assign op = rsb_op_e'(op_sel);

    logic [DATA_W-1:0] sh_res;
    logic              sh_carry;
    logic              sh_sign, sh_zero, sh_par;
    logic [DATA_W-1:0] bt_flags;
    logic [DATA_W-1:0] xy_src;

    rsb_shift_core #(.W(DATA_W)) shift_i (
        .op   (op),
        .val  (val_in),
        .cin  (flags_in[FL_C]),
        .res  (sh_res),
        .cout (sh_carry)
    );

    rsb_sz_flags #(.W(DATA_W)) szf_i (
        .res      (sh_res),
        .sign     (sh_sign),
        .zero     (sh_zero),
        .par_even (sh_par)
    );

    assign xy_src = (op == OP_BITX) ? addr_hi : val_in;

    rsb_bit_test #(.W(DATA_W), .IW(IDX_W)) bit_i (
        .val    (val_in),
        .idx    (bit_idx),
        .xy_src (xy_src),
        .cin    (flags_in[FL_C]),
        .flags  (bt_flags)
    );

    always_comb begin
        val_out   = val_in;
        flags_out = flags_in;
        unique case (op)
            OP_RLC, OP_RRC, OP_RL, OP_RR,
            OP_SLA, OP_SRA, OP_SLL, OP_SRL: begin
                val_out          = sh_res;
                flags_out        = sh_res & XY_MASK;
                flags_out[FL_C]  = sh_carry;
                flags_out[FL_N]  = 1'b0;
                flags_out[FL_H]  = 1'b0;
                flags_out[FL_PV] = sh_par;
                flags_out[FL_Z]  = sh_zero;
                flags_out[FL_S]  = sh_sign;
            end
            OP_BIT, OP_BITX: begin
                val_out   = val_in;
                flags_out = bt_flags;
            end
            default: begin
                val_out   = val_in;
                flags_out = flags_in;
            end
        endcase
    end
endmodule

// File: rtl/rsb_unit_chk.sv
`timescale 1ns/1ps
module rsb_unit_chk
    import rsb_pkg::*;
(
    input logic [OP_W-1:0]   op_sel,
    input logic [DATA_W-1:0] val_in,
    input logic [DATA_W-1:0] flags_in,
    input logic [IDX_W-1:0]  bit_idx,
    input logic [DATA_W-1:0] val_out,
    input logic [DATA_W-1:0] flags_out
);
    logic is_shift, is_bit, is_undef;
    assign is_shift = (op_sel < 4'd8);
    assign is_bit   = (op_sel == 4'd8) || (op_sel == 4'd9);
    assign is_undef = (op_sel > 4'd9);

    always_comb begin
        AST_RLC_WRAP: assert (!(op_sel == 4'd0) || (val_out[0] == val_in[DATA_W-1] && flags_out[FL_C] == val_in[DATA_W-1])) else $error("rlc wrap"); // R1
        AST_SHIFT_HN_CLEAR: assert (!is_shift || (!flags_out[FL_H] && !flags_out[FL_N])) else $error("h/n set"); // R6
        AST_SHIFT_ZERO_FLAG: assert (!is_shift || (flags_out[FL_Z] == (val_out == '0))) else $error("zero flag"); // R6
        AST_BIT_KEEPS_VALUE: assert (!is_bit || (val_out == val_in && flags_out[FL_C] == flags_in[FL_C])) else $error("bit value"); // R7
        AST_BIT_Z_TRACKS_PV: assert (!is_bit || (flags_out[FL_Z] == flags_out[FL_PV] && flags_out[FL_Z] == !val_in[bit_idx])) else $error("bit z/pv"); // R7
        AST_BIT_SIGN_RULE: assert (!is_bit || (flags_out[FL_S] == (bit_idx == 3'd7 && val_in[DATA_W-1]))) else $error("bit sign"); // R8
        AST_UNDEF_PASS: assert (!is_undef || (val_out == val_in && flags_out == flags_in)) else $error("undef pass"); // R11
    end
endmodule

bind rsb_unit rsb_unit_chk chk_i (
    .op_sel    (op_sel),
    .val_in    (val_in),
    .flags_in  (flags_in),
    .bit_idx   (bit_idx),
    .val_out   (val_out),
    .flags_out (flags_out)
);

// File: tb/rsb_unit_tb_top.sv
`timescale 1ns/1ps
module rsb_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_sel = '0;
    logic [7:0] val_in = '0, flags_in = '0, addr_hi = '0;
    logic [2:0] bit_idx = '0;
    logic [7:0] val_out, flags_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;   // 50 MHz

    rsb_unit dut_i (
        .op_sel(op_sel), .val_in(val_in), .flags_in(flags_in),
        .bit_idx(bit_idx), .addr_hi(addr_hi),
        .val_out(val_out), .flags_out(flags_out)
    );

    // Expected {result, flags} worked out from the requirement text
    function automatic logic [15:0] model(int op, logic [7:0] v, logic [7:0] f, int idx, logic [7:0] ah);
        logic [7:0] r;
        logic [7:0] nf;
        logic [7:0] src;
        logic       c;
        logic       zb;
        r = v;
        c = f[0];
        case (op)
            0: begin r = {v[6:0], v[7]}; c = v[7]; end
            1: begin r = {v[0], v[7:1]}; c = v[0]; end
            2: begin r = {v[6:0], f[0]}; c = v[7]; end
            3: begin r = {f[0], v[7:1]}; c = v[0]; end
            4: {c, r} = {v, 1'b0};
            5: begin r = {v[7], v[7:1]}; c = v[0]; end
            6: {c, r} = {v, 1'b1};
            7: begin r = {1'b0, v[7:1]}; c = v[0]; end
            default: r = v;
        endcase
        if (op < 8) begin
            nf = {r[7], (r == 8'h00), r[5], 1'b0, r[3], ~^r, 1'b0, c};
        end else if (op < 10) begin
            src = (op == 9) ? ah : v;
            zb  = ~v[idx];
            nf  = {(idx == 7) && v[7], zb, src[5], 1'b1, src[3], zb, 1'b0, f[0]};
        end else begin
            nf = f;
        end
        return {r, nf};
    endfunction

    task automatic drive(int op, logic [7:0] v, logic [7:0] f, int idx, logic [7:0] ah, string tag);
        @(posedge clk);
        #1;
        op_sel   = 4'(op);
        val_in   = v;
        flags_in = f;
        bit_idx  = 3'(idx);
        addr_hi  = ah;
        exp_q.push_back(model(op, v, f, idx, ah));
        tag_q.push_back(tag);
    endtask

    // Monitor: one scoreboard item per cycle, sampled mid-period
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if ({val_out, flags_out} !== e) begin
                n_fail++;
                $display("FAIL %s: got val=%02h flags=%02h expected val=%02h flags=%02h (op=%0d in=%02h f=%02h idx=%0d ah=%02h)",
                         t, val_out, flags_out, e[15:8], e[7:0], op_sel, val_in, flags_in, bit_idx, addr_hi);
            end
        end
    end

    string op_tag[8] = '{"R1,R6", "R2,R6", "R3,R6", "R3,R6", "R4,R6", "R5,R6", "R4,R6", "R5,R6"};

    initial begin
        // Reset state: zero inputs under code 0 give zero result, Z and P set (R6)
        drive(0, 8'h00, 8'h00, 0, 8'h00, "R6 reset");
        repeat (2) @(posedge clk);
        rst = 1'b0;

        // Directed corners
        drive(0, 8'h81, 8'h00, 0, 8'h00, "R1");          // -> 03, C
        drive(1, 8'h01, 8'h00, 0, 8'h00, "R2");          // -> 80, C
        drive(2, 8'h00, 8'h01, 0, 8'h00, "R3");          // carry enters bit 0
        drive(3, 8'h00, 8'h01, 0, 8'h00, "R3");          // carry enters bit 7
        drive(6, 8'h80, 8'h00, 0, 8'h00, "R4");          // -> 01, C
        drive(4, 8'h80, 8'h00, 0, 8'h00, "R4");          // -> 00, Z P C
        drive(5, 8'h81, 8'h00, 0, 8'h00, "R5");          // -> C0, C
        drive(7, 8'h81, 8'h00, 0, 8'h00, "R5");          // -> 40, C
        drive(7, 8'h01, 8'hFF, 0, 8'h00, "R6");          // H N cleared from all-ones

        // Full sweep of shift/rotate codes with both carry inputs
        for (int op = 0; op < 8; op++)
            for (int cf = 0; cf < 2; cf++)
                for (int v = 0; v < 256; v++)
                    drive(op, 8'(v), cf ? 8'h01 : 8'hFE, 0, 8'h00, op_tag[op]);

        // Bit test across all indices, single-bit and single-hole operands
        for (int i = 0; i < 8; i++) begin
            drive(8, 8'(1 << i), 8'h00, i, 8'h00, "R7,R8");
            drive(8, ~8'(1 << i), 8'h01, i, 8'h00, "R7,R8");
            drive(8, 8'hFF, 8'h00, i, 8'h00, "R8");
            drive(8, 8'h28, 8'hFF, i, 8'hD7, "R9");
            drive(9, 8'h00, 8'h00, i, 8'h28, "R10");
            drive(9, 8'hFF, 8'h01, i, 8'h00, "R10");
        end

        // Undefined codes pass everything through
        for (int op = 10; op < 16; op++) begin
            drive(op, 8'hA5, 8'h01, 3, 8'h55, "R11");
            drive(op, 8'h00, 8'hFF, 7, 8'h00, "R11");
        end

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule